// File: doc/BRIEF.md
# Function Power-State and Reset-Domain Controller

This block holds the device power state of one PCI function and decides, for every reset event, which groups of configuration bits may be wiped. It takes a global reset, a PCI reset and a suspend input, along with configuration writes to the command enables and the power-management control/status word, plus a wake-event input. It tracks six internal states: uninitialized D0, active D0, D1, D2, D3hot and D3cold. Software sees only a 2-bit state code.

Three clear strobes go to the rest of the function's registers. The first clears ordinary bits on any reset. The second clears wake-context bits, but a PCI reset asserts it only while wake signalling is disabled. The third clears global-only bits, and only the global reset asserts it. While suspend is high, the global reset is masked inside the block, so no strobe fires and no state moves.

The block also produces the wake request, a flag that permits interrupts, and the read-back of the capability header and the control/status word.

Top module: `pm_rstdom_ctrl`

## Requirements
- R1: A global reset with suspend low puts the function in uninitialized D0 one clock later. It also clears the wake-enable and wake-status bits, so the state code reads 0.
- R2: In uninitialized D0, a command write (cfg_sel=0) that leaves data bits 0 and 1 both set moves the function to active D0 on the next clock. irq_allow is 1 only in active D0.
- R3: A control/status write (cfg_sel=1) takes its target state from data bits 1:0: 0=D0 active, 1=D1, 2=D2, 3=D3hot. A code for a state the function lacks (D2 by default) is ignored and the old state is kept. Power-state writes made in uninitialized D0 are ignored.
- R4: The wake-status bit (read-back bit 15) is set by pme_evt in any state except uninitialized D0. Writing 1 to data bit 15 clears it. If an event and a clearing write fall in the same cycle, the event wins and the bit stays 1.
- R5: pme_req is high while wake-status and wake-enable are both 1 and the state is not uninitialized D0. It is low in the cycle after the status bit is cleared.
- R6: A PCI reset returns the state to uninitialized D0, except from D3hot, where the state goes to D3cold (code 3). Leaving D3cold requires prst low, and the state then moves to uninitialized D0.
- R7: clr_pme_ctx follows prst only while wake-enable is 0. clr_grst_only never follows prst. clr_ordinary follows any reset that is not masked. Wake-status survives a PCI reset when wake-enable is 1.
- R8: While suspend is high, a global reset has no effect. No strobe fires, and the state, wake-enable and wake-status keep their values.
- R9: cap_hdr reads the capability ID 01h in bits 7:0 and the NEXT_PTR parameter (default 0) in bits 15:8.
- R10: Wake-enable is data bit 8 of a control/status write (read-back bit 8) and only an unmasked global reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst | input | 1 | Global reset, active high, synchronous |
| prst | input | 1 | PCI reset, active high, synchronous |
| suspend | input | 1 | Masks the global reset while high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = command word, 1 = power control/status word |
| cfg_wdata | input | 16 | Write data |
| pme_evt | input | 1 | Wake event from the function |
| pwr_state | output | 2 | Software-visible power-state code |
| pmcsr_rd | output | 16 | Control/status read-back: bit 15 status, bit 8 enable, bits 1:0 state |
| cap_hdr | output | 16 | Capability header: next pointer, ID |
| pme_req | output | 1 | Wake request |
| irq_allow | output | 1 | Interrupts permitted |
| clr_ordinary | output | 1 | Clear strobe for ordinary bits |
| clr_pme_ctx | output | 1 | Clear strobe for wake-context bits |
| clr_grst_only | output | 1 | Clear strobe for global-only bits |

## Verification
Two functions can act on the wake-status bit in the same cycle: a wake event sets it, and a write-one-to-clear from software clears it. The bench applies both on one edge in active D0 and expects the bit and pme_req to read 1 afterwards. It also applies a PCI reset while wake-enable is 1 and checks that the status bit survives. Separately, it raises global reset and suspend together and expects every output to hold.

// File: rtl/pm_rstdom_ctrl.sv
module pm_rstdom_ctrl #(
  parameter bit         HAS_D1   = 1'b1,
  parameter bit         HAS_D2   = 1'b0,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic        clk,
  input  logic        grst,
  input  logic        prst,
  input  logic        suspend,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        pme_evt,
  output logic [1:0]  pwr_state,
  output logic [15:0] pmcsr_rd,
  output logic [15:0] cap_hdr,
  output logic        pme_req,
  output logic        irq_allow,
  output logic        clr_ordinary,
  output logic        clr_pme_ctx,
  output logic        clr_grst_only
);

  typedef enum logic [2:0] {S_D0U, S_D0A, S_D1, S_D2, S_D3H, S_D3C} pst_t;

  pst_t st, nxt;
  logic io_en, mem_en, pme_en, pme_st;

  wire g_eff  = grst & ~suspend;
  wire wr_cmd = cfg_wr & ~cfg_sel;
  wire wr_pm  = cfg_wr & cfg_sel;
  wire [1:0] code = cfg_wdata[1:0];
  wire cmd_ok = wr_cmd ? (cfg_wdata[0] & cfg_wdata[1]) : (io_en & mem_en);
  wire code_ok = (code == 2'd1) ? HAS_D1 : (code == 2'd2) ? HAS_D2 : 1'b1;

  assign clr_grst_only = g_eff;
  assign clr_ordinary  = g_eff | prst;
  assign clr_pme_ctx   = g_eff | (prst & ~pme_en);

  always_comb begin
    nxt = st;
    if (prst) begin
      nxt = (st == S_D3H || st == S_D3C) ? S_D3C : S_D0U;
    end else begin
      case (st)
        S_D3C: nxt = S_D0U;
        S_D0U: if (cmd_ok) nxt = S_D0A;
        default:
          if (wr_pm && code_ok) begin
            case (code)
              2'd0:    nxt = S_D0A;
              2'd1:    nxt = S_D1;
              2'd2:    nxt = S_D2;
              default: nxt = S_D3H;
            endcase
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (g_eff) st <= S_D0U;
    else       st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (clr_ordinary) begin
      io_en  <= 1'b0;
      mem_en <= 1'b0;
    end else if (wr_cmd) begin
      io_en  <= cfg_wdata[0];
      mem_en <= cfg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (g_eff)      pme_en <= 1'b0;
    else if (wr_pm) pme_en <= cfg_wdata[8];
  end

  always_ff @(posedge clk) begin
    if (clr_pme_ctx)                      pme_st <= 1'b0;
    else if (pme_evt && st != S_D0U)      pme_st <= 1'b1;
    else if (wr_pm && cfg_wdata[15])      pme_st <= 1'b0;
  end

  always_comb begin
    case (st)
      S_D1:         pwr_state = 2'd1;
      S_D2:         pwr_state = 2'd2;
      S_D3H, S_D3C: pwr_state = 2'd3;
      default:      pwr_state = 2'd0;
    endcase
  end

  assign pmcsr_rd  = {pme_st, 6'b0, pme_en, 6'b0, pwr_state};
  assign cap_hdr   = {NEXT_PTR, 8'h01};
  assign pme_req   = pme_st & pme_en & (st != S_D0U);
  assign irq_allow = (st == S_D0A);

  // R1
  grst_init_chk: assert property (@(posedge clk) disable iff (suspend)
    g_eff |=> (st == S_D0U) && !pme_en && !pme_st);

  // R2
  d0_enter_chk: assert property (@(posedge clk) disable iff (g_eff)
    (st == S_D0U) && !prst && wr_cmd && (&cfg_wdata[1:0]) |=> irq_allow);

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (g_eff)
    wr_pm && !prst && !code_ok && st != S_D3C |=> $stable(pwr_state));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (g_eff)
    wr_pm && cfg_wdata[15] && !pme_evt && !prst |=> !pmcsr_rd[15]);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (g_eff)
    wr_pm && cfg_wdata[15] && !pme_evt && !prst |=> !pme_req);

  // R6
  cold_exit_chk: assert property (@(posedge clk) disable iff (g_eff)
    (st == S_D3C) && !prst |=> (st == S_D0U));

  // R7
  ctx_keep_chk: assert property (@(posedge clk) disable iff (g_eff)
    prst && pme_en && pme_st && !wr_pm |=> pmcsr_rd[15]);

  // R7
  grst_only_chk: assert property (@(posedge clk) disable iff (g_eff)
    prst |-> !clr_grst_only);

  // R8
  susp_hold_chk: assert property (@(posedge clk) disable iff (g_eff)
    suspend && grst && !prst && !cfg_wr && !pme_evt && st != S_D3C
    |=> $stable(st) && $stable(pme_en) && $stable(pme_st));

endmodule

// File: tb/pm_rstdom_ctrl_tb.sv
module pm_rstdom_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic grst = 1'b1, prst = 1'b0, suspend = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0, pme_evt = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [1:0]  pwr_state;
  logic [15:0] pmcsr_rd, cap_hdr;
  logic pme_req, irq_allow, clr_ordinary, clr_pme_ctx, clr_grst_only;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pm_rstdom_ctrl u_dut (
    .clk(clk), .grst(grst), .prst(prst), .suspend(suspend),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pme_evt(pme_evt),
    .pwr_state(pwr_state), .pmcsr_rd(pmcsr_rd), .cap_hdr(cap_hdr),
    .pme_req(pme_req), .irq_allow(irq_allow), .clr_ordinary(clr_ordinary),
    .clr_pme_ctx(clr_pme_ctx), .clr_grst_only(clr_grst_only)
  );

  // inputs: grst prst susp wr sel d15 d8 d[1:0] evt | expected: code status enable req irq
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'b1_0_0_0_0_0_0_00_0_00_0_0_0_0,
    16'b0_0_0_0_0_0_0_00_1_00_0_0_0_0,
    16'b0_0_0_1_0_0_0_11_0_00_0_0_0_1,
    16'b0_0_0_0_0_0_0_00_1_00_1_0_0_1,
    16'b0_0_0_1_1_0_1_00_0_00_1_1_1_1,
    16'b0_0_0_1_1_1_1_00_0_00_0_1_0_1,
    16'b0_0_0_1_1_0_1_10_0_00_0_1_0_1,
    16'b0_0_0_1_1_0_1_01_0_01_0_1_0_0,
    16'b0_0_0_0_0_0_0_00_1_01_1_1_1_0,
    16'b0_0_0_1_1_0_1_11_0_11_1_1_1_0,
    16'b0_1_0_0_0_0_0_00_0_11_1_1_1_0,
    16'b0_0_0_0_0_0_0_00_0_00_1_1_0_0,
    16'b0_0_0_1_1_1_1_00_0_00_0_1_0_0,
    16'b0_0_0_1_0_0_0_11_0_00_0_1_0_1,
    16'b0_0_0_1_1_0_0_00_0_00_0_0_0_1,
    16'b0_0_0_0_0_0_0_00_1_00_1_0_0_1,
    16'b0_1_0_0_0_0_0_00_0_00_0_0_0_0,
    16'b0_0_0_0_0_0_0_00_0_00_0_0_0_0,
    16'b0_0_0_1_0_0_0_11_0_00_0_0_0_1,
    16'b0_0_0_1_1_0_1_00_0_00_0_1_0_1,
    16'b0_0_0_1_1_1_1_00_1_00_1_1_1_1,
    16'b1_0_1_0_0_0_0_00_0_00_1_1_1_1,
    16'b0_1_0_0_0_0_0_00_0_00_1_1_0_0,
    16'b1_0_0_0_0_0_0_00_0_00_0_0_0_0
  };

  function automatic string tag(int i);
    case (i)
      0, 23:          return "R1";
      2, 13, 18:      return "R2";
      6, 7, 9:        return "R3";
      1, 3, 12, 20:   return "R4";
      5, 8, 15:       return "R5";
      10, 11, 17:     return "R6";
      16, 22:         return "R7";
      21:             return "R8";
      default:        return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(PERIOD*4000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      grst = v[15]; prst = v[14]; suspend = v[13]; cfg_wr = v[12]; cfg_sel = v[11];
      cfg_wdata = {v[10], 6'b0, v[9], 6'b0, v[8:7]};
      pme_evt = v[6];
      @(negedge clk);
      chk(tag(i), $sformatf("row %0d code/status/enable/req/irq", i),
          {11'b0, pwr_state, pmcsr_rd[15], pmcsr_rd[8], pme_req, irq_allow},
          {11'b0, v[5:0]});
    end

    // R9 capability header
    chk("R9", "cap_hdr", cap_hdr, 16'h0001);

    // R7 strobes for PCI reset with enable clear, then set
    grst = 1'b0; prst = 1'b0; suspend = 1'b0; cfg_wr = 1'b0; pme_evt = 1'b0;
    @(negedge clk);
    prst = 1'b1; #1;
    chk("R7", "strobes prst en=0", {13'b0, clr_ordinary, clr_pme_ctx, clr_grst_only}, 16'b110);
    prst = 1'b0; cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h0100;
    @(negedge clk);
    cfg_wr = 1'b0; prst = 1'b1; #1;
    chk("R7", "strobes prst en=1", {13'b0, clr_ordinary, clr_pme_ctx, clr_grst_only}, 16'b100);
    prst = 1'b0;
    @(negedge clk);
    chk("R10", "enable after prst", {15'b0, pmcsr_rd[8]}, 16'h1);

    // R8 masked global reset fires nothing
    grst = 1'b1; suspend = 1'b1; #1;
    chk("R8", "strobes masked", {13'b0, clr_ordinary, clr_pme_ctx, clr_grst_only}, 16'b000);
    suspend = 1'b0; #1;
    chk("R1", "strobes global", {13'b0, clr_ordinary, clr_pme_ctx, clr_grst_only}, 16'b111);
    @(negedge clk);
    grst = 1'b0;
    chk("R1", "enable cleared", {15'b0, pmcsr_rd[8]}, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule